// File: doc/BRIEF.md
# Multi-Style Host Bus Register Port

This block is an 8-bit parallel slave port. It lets an external microcontroller read and write a register file inside the chip. It accepts three host bus styles.

- **Separate-strobe style**: chip select plus individual write and read strobes.
- **Strobe-and-direction style**: chip select, a direction line and a data strobe.
- **Multiplexed style**: the address and the data share one byte-wide bus, and an address-latch pulse separates the two phases.

The host never programs the style. The port reads it from the address-latch pin. A steady low level means separate-strobe style. A steady high level means strobe-and-direction style. The first transition of the pin in either direction selects multiplexed style, and that choice holds until reset.

A strap input picks the addressing scheme:

- **Direct**: the full byte address names the register.
- **Indirect**: only address bit 0 is decoded. It selects either an internal pointer register or a data window onto the register that the pointer names.

All host pins are asynchronous to the core clock. They pass through a synchronizer before any decoding. Toward the register file the block drives an address, write data, a one-cycle write strobe and a one-cycle read strobe. Read data returns combinationally on `reg_rdata`. Toward the pads the block drives read data and an output enable for the tri-state data buffer.

Top module: `hostbus_port`

## Requirements
- R1: While `rst` is high and after it falls, `reg_we`, `reg_re` and `bus_ad_oe` are low. The port then starts in one of the two non-multiplexed styles, chosen by the static level of `bus_ale`.
- R2: With `bus_ale` held low (separate-strobe style), a write commits on the rising edge of `bus_wr_n` while `bus_cs_n` is low. A read is in progress while `bus_rd_n` and `bus_cs_n` are low. Activity on `bus_ds_n` and `bus_rw` causes no write.
- R3: With `bus_ale` held high (strobe-and-direction style), a write commits on the rising edge of `bus_ds_n` while `bus_rw` is 0 and `bus_cs_n` is low. A read is in progress while `bus_ds_n` is low, `bus_rw` is 1 and `bus_cs_n` is low. `bus_wr_n` and `bus_rd_n` cause neither a write nor an output enable.
- R4: Any transition of `bus_ale` after reset switches the port to multiplexed style, which then uses the separate-strobe rules for writes and reads. A later steady level of `bus_ale` does not change the style back. Only `rst` returns the port to level-selected style.
- R5: In multiplexed style the access address is the value on `bus_ad_in` at the falling edge of `bus_ale`. It is kept until the next falling edge, and `bus_addr` is ignored.
- R6: Each committed write gives exactly one cycle of `reg_we`, with `reg_wdata` equal to `bus_ad_in` at the trailing strobe edge. `reg_we` rises on the third rising clock edge after that strobe edge. Strobes given while `bus_cs_n` is high commit nothing.
- R7: With `strap_indirect` at 0, all 8 address bits select the register, and `reg_addr` equals that address.
- R8: With `strap_indirect` at 1, only address bit 0 is decoded, and all other address bits are ignored. A write with bit 0 = 0 loads the pointer and gives no `reg_we`. A read with bit 0 = 0 returns the pointer and gives no `reg_re`. `reg_addr` changes only after the pointer is written.
- R9: With `strap_indirect` at 1 and address bit 0 = 1, writes and reads go to the register whose address is held in the pointer.
- R10: `bus_ad_oe` is high only while `bus_cs_n` is low and a read is in progress. While it is high, `bus_ad_out` carries the selected register's data (or the pointer, per R8). Each read of the register file gives one cycle of `reg_re`. `reg_we` and `reg_re` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_indirect | input | 1 | 0 = direct addressing, 1 = pointer/data-window addressing |
| bus_ale | input | 1 | Address-latch pin; its level or its activity selects the bus style |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_wr_n | input | 1 | Write strobe, active low (separate-strobe and multiplexed styles) |
| bus_rd_n | input | 1 | Read strobe, active low (separate-strobe and multiplexed styles) |
| bus_rw | input | 1 | Direction, 1 = read, 0 = write (strobe-and-direction style) |
| bus_ds_n | input | 1 | Data strobe, active low (strobe-and-direction style) |
| bus_addr | input | 8 | Separate address bus |
| bus_ad_in | input | 8 | Data, or address/data, bus as driven by the host |
| bus_ad_out | output | 8 | Read data toward the pad buffer |
| bus_ad_oe | output | 1 | Output enable of the pad buffer |
| reg_addr | output | 8 | Register-file address |
| reg_wdata | output | 8 | Register-file write data |
| reg_we | output | 1 | Register-file write strobe, one cycle |
| reg_re | output | 1 | Register-file read strobe, one cycle |
| reg_rdata | input | 8 | Register-file read data for `reg_addr` |

## Verification
Every host pin passes through two synchronizer stages, and every result then goes through one output register. A write strobe or read strobe therefore appears on the third rising clock edge after the pin change that causes it. `bus_ad_oe` follows `bus_cs_n` and the read strobe with the same three-edge delay. `bus_ad_out` needs one more edge after `reg_addr` settles. Style detection also takes three edges after an address-latch transition. The bench drives the pins on falling clock edges and holds each bus phase for four clocks, so every sample it takes on a falling edge falls after the result is due. One directed test of write-strobe timing samples on the falling edges just after the second, third and fourth rising edges following the trailing strobe edge. It expects `reg_we` to be low, then high, then low again.

// File: rtl/hb_pkg.sv
package hb_pkg;

  typedef enum logic [1:0] {
    BS_SEPARATE = 2'd0,
    BS_STROBE   = 2'd1,
    BS_MUXED    = 2'd2
  } bus_style_e;

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk) chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/hb_mode_detect.sv
module hb_mode_detect
  import hb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ale_s,
  output bus_style_e style_q,
  output logic       ale_fall
);

  logic ale_prev;
  logic mux_q;
  logic ale_edge;

  always_ff @(posedge clk) ale_prev <= ale_s;

  assign ale_edge = ale_s ^ ale_prev;
  assign ale_fall = !rst && ale_prev && !ale_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      mux_q   <= 1'b0;
      style_q <= ale_s ? BS_STROBE : BS_SEPARATE;
    end else begin
      if (ale_edge) mux_q <= 1'b1;
      if (mux_q || ale_edge)
        style_q <= BS_MUXED;
      else
        style_q <= ale_s ? BS_STROBE : BS_SEPARATE;
    end
  end

  // R4: multiplexed selection never drops back without reset
  p_mux_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    mux_q |=> mux_q);

endmodule

// File: rtl/hb_strobe_decode.sv
module hb_strobe_decode
  import hb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  bus_style_e style,
  input  logic       cs_n_s,
  input  logic       wr_n_s,
  input  logic       rd_n_s,
  input  logic       rw_s,
  input  logic       ds_n_s,
  output logic       wr_commit,
  output logic       rd_start,
  output logic       rd_active
);

  logic wr_act, rd_act, cs_act;
  logic wr_prev, rd_prev;

  always_comb begin
    if (style == BS_STROBE) begin
      wr_act = !ds_n_s && !rw_s;
      rd_act = !ds_n_s &&  rw_s;
    end else begin
      wr_act = !wr_n_s;
      rd_act = !rd_n_s;
    end
  end

  assign cs_act = !cs_n_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_prev <= 1'b0;
      rd_prev <= 1'b0;
    end else begin
      wr_prev <= wr_act;
      rd_prev <= rd_act;
    end
  end

  assign wr_commit = cs_act && wr_prev && !wr_act;
  assign rd_start  = cs_act && !rd_prev && rd_act;
  assign rd_active = cs_act && rd_act;

endmodule

// File: rtl/hb_access.sv
module hb_access
  import hb_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         strap_ind,
  input  bus_style_e   style,
  input  logic         ale_fall,
  input  logic [W-1:0] addr_s,
  input  logic [W-1:0] ad_s,
  input  logic         wr_commit,
  input  logic         rd_start,
  input  logic         rd_active,
  input  logic [W-1:0] reg_rdata,
  output logic [W-1:0] reg_addr,
  output logic [W-1:0] reg_wdata,
  output logic         reg_we,
  output logic         reg_re,
  output logic [W-1:0] bus_dout,
  output logic         bus_doe
);

  logic [W-1:0] lat_addr;
  logic [W-1:0] ptr_q;
  logic [W-1:0] eff_addr;
  logic [W-1:0] target;
  logic         sel_ptr;

  always_ff @(posedge clk) begin
    if (rst)           lat_addr <= '0;
    else if (ale_fall) lat_addr <= ad_s;
  end

  assign eff_addr = (style == BS_MUXED) ? lat_addr : addr_s;
  assign sel_ptr  = strap_ind && !eff_addr[0];
  assign target   = strap_ind ? ptr_q : eff_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q     <= '0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_we    <= 1'b0;
      reg_re    <= 1'b0;
      bus_dout  <= '0;
      bus_doe   <= 1'b0;
    end else begin
      reg_addr <= target;
      reg_we   <= wr_commit && !sel_ptr;
      reg_re   <= rd_start && !sel_ptr;
      if (wr_commit) reg_wdata <= ad_s;
      if (wr_commit && sel_ptr) ptr_q <= ad_s;
      bus_doe  <= rd_active;
      bus_dout <= sel_ptr ? ptr_q : reg_rdata;
    end
  end

  // R6: a write strobe lasts one cycle
  p_we_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);

  // R10: write and read strobes are exclusive
  p_no_rw_overlap_r10: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && reg_re));

  // R8: in indirect mode the register address moves only after a pointer update
  p_ptr_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (strap_ind && $stable(ptr_q)) |=> $stable(reg_addr));

endmodule

// File: rtl/hostbus_port.sv
module hostbus_port
  import hb_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         strap_indirect,
  input  logic         bus_ale,
  input  logic         bus_cs_n,
  input  logic         bus_wr_n,
  input  logic         bus_rd_n,
  input  logic         bus_rw,
  input  logic         bus_ds_n,
  input  logic [W-1:0] bus_addr,
  input  logic [W-1:0] bus_ad_in,
  output logic [W-1:0] bus_ad_out,
  output logic         bus_ad_oe,
  output logic [W-1:0] reg_addr,
  output logic [W-1:0] reg_wdata,
  output logic         reg_we,
  output logic         reg_re,
  input  logic [W-1:0] reg_rdata
);

  localparam int CTRL_W = 6;
  localparam int PINS_W = CTRL_W + 2 * W;

  logic [PINS_W-1:0] pins_raw, pins_s;
  logic              ale_s, cs_n_s, wr_n_s, rd_n_s, rw_s, ds_n_s;
  logic [W-1:0]      addr_s, ad_s;
  bus_style_e        style;
  logic              ale_fall, wr_commit, rd_start, rd_active;

  assign pins_raw = {bus_ale, bus_cs_n, bus_wr_n, bus_rd_n, bus_rw, bus_ds_n,
                     bus_addr, bus_ad_in};

  hb_sync #(.W(PINS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (pins_raw),
    .q   (pins_s)
  );

  assign {ale_s, cs_n_s, wr_n_s, rd_n_s, rw_s, ds_n_s, addr_s, ad_s} = pins_s;

  hb_mode_detect u_mode (
    .clk      (clk),
    .rst      (rst),
    .ale_s    (ale_s),
    .style_q  (style),
    .ale_fall (ale_fall)
  );

  hb_strobe_decode u_strobe (
    .clk       (clk),
    .rst       (rst),
    .style     (style),
    .cs_n_s    (cs_n_s),
    .wr_n_s    (wr_n_s),
    .rd_n_s    (rd_n_s),
    .rw_s      (rw_s),
    .ds_n_s    (ds_n_s),
    .wr_commit (wr_commit),
    .rd_start  (rd_start),
    .rd_active (rd_active)
  );

  hb_access #(.W(W)) u_access (
    .clk       (clk),
    .rst       (rst),
    .strap_ind (strap_indirect),
    .style     (style),
    .ale_fall  (ale_fall),
    .addr_s    (addr_s),
    .ad_s      (ad_s),
    .wr_commit (wr_commit),
    .rd_start  (rd_start),
    .rd_active (rd_active),
    .reg_rdata (reg_rdata),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .reg_re    (reg_re),
    .bus_dout  (bus_ad_out),
    .bus_doe   (bus_ad_oe)
  );

endmodule

// File: tb/hostbus_port_bench.sv
`timescale 1ns/1ps
module hostbus_port_bench;

  logic       clk = 1'b0;
  logic       rst;
  logic       strap_indirect;
  logic       bus_ale, bus_cs_n, bus_wr_n, bus_rd_n, bus_rw, bus_ds_n;
  logic [7:0] bus_addr, bus_ad_in, bus_ad_out;
  logic       bus_ad_oe;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       reg_we, reg_re;

  always #10 clk = ~clk;

  hostbus_port u_hostbus_port (
    .clk            (clk),
    .rst            (rst),
    .strap_indirect (strap_indirect),
    .bus_ale        (bus_ale),
    .bus_cs_n       (bus_cs_n),
    .bus_wr_n       (bus_wr_n),
    .bus_rd_n       (bus_rd_n),
    .bus_rw         (bus_rw),
    .bus_ds_n       (bus_ds_n),
    .bus_addr       (bus_addr),
    .bus_ad_in      (bus_ad_in),
    .bus_ad_out     (bus_ad_out),
    .bus_ad_oe      (bus_ad_oe),
    .reg_addr       (reg_addr),
    .reg_wdata      (reg_wdata),
    .reg_we         (reg_we),
    .reg_re         (reg_re),
    .reg_rdata      (reg_rdata)
  );

  // register file model
  logic [7:0] mem [256];
  int         we_cnt = 0;
  int         re_cnt = 0;
  logic [7:0] last_wa = '0;
  logic [7:0] last_wd = '0;

  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) begin
    if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
      we_cnt        <= we_cnt + 1;
      last_wa       <= reg_addr;
      last_wd       <= reg_wdata;
    end
    if (reg_re) re_cnt <= re_cnt + 1;
  end

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;

  // {address, data}
  localparam logic [15:0] VEC [0:5] = '{
    16'h03A5, 16'h7F3C, 16'h8001, 16'hFE99, 16'h00FF, 16'h5566
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    repeat (4) @(negedge clk);
  endtask

  task automatic idle_pins();
    bus_cs_n = 1'b1; bus_wr_n = 1'b1; bus_rd_n = 1'b1;
    bus_rw = 1'b1; bus_ds_n = 1'b1;
  endtask

  task automatic do_reset(input logic strap, input logic ale);
    @(negedge clk);
    idle_pins();
    strap_indirect = strap;
    bus_ale = ale;
    rst = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    step();
  endtask

  task automatic wr_sep(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_ad_in = d; step();
    bus_cs_n = 1'b0; step();
    bus_wr_n = 1'b0; step();
    bus_wr_n = 1'b1; step();
    bus_cs_n = 1'b1; step();
  endtask

  task automatic rd_sep(input logic [7:0] a, output logic [7:0] d, output logic oe);
    bus_addr = a; step();
    bus_cs_n = 1'b0; step();
    bus_rd_n = 1'b0; step(); step();
    d = bus_ad_out; oe = bus_ad_oe;
    bus_rd_n = 1'b1; step();
    bus_cs_n = 1'b1; step();
  endtask

  task automatic wr_strb(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_ad_in = d; bus_rw = 1'b0; step();
    bus_cs_n = 1'b0; step();
    bus_ds_n = 1'b0; step();
    bus_ds_n = 1'b1; step();
    bus_cs_n = 1'b1; bus_rw = 1'b1; step();
  endtask

  task automatic rd_strb(input logic [7:0] a, output logic [7:0] d, output logic oe);
    bus_addr = a; bus_rw = 1'b1; step();
    bus_cs_n = 1'b0; step();
    bus_ds_n = 1'b0; step(); step();
    d = bus_ad_out; oe = bus_ad_oe;
    bus_ds_n = 1'b1; step();
    bus_cs_n = 1'b1; step();
  endtask

  task automatic latch_addr(input logic [7:0] a);
    bus_ad_in = a; bus_ale = 1'b1; step();
    bus_ale = 1'b0; step();
  endtask

  logic [7:0] rdv;
  logic       oev;
  int         base_we, base_re;

  initial begin
    rst = 1'b1;
    strap_indirect = 1'b0;
    bus_ale = 1'b0;
    bus_addr = '0;
    bus_ad_in = '0;
    idle_pins();

    // ---------- separate-strobe, direct ----------
    do_reset(1'b0, 1'b0);
    chk("R1 reg_we after reset", reg_we, 0);
    chk("R1 reg_re after reset", reg_re, 0);
    chk("R1 oe after reset", bus_ad_oe, 0);

    foreach (VEC[i]) begin
      wr_sep(VEC[i][15:8], VEC[i][7:0]);
      chk("R7 write address", last_wa, VEC[i][15:8]);
      chk("R6 write data", last_wd, VEC[i][7:0]);
    end
    chk("R6 one strobe per write", we_cnt, 6);
    base_re = re_cnt;
    foreach (VEC[i]) begin
      rd_sep(VEC[i][15:8], rdv, oev);
      chk("R2 read data", rdv, VEC[i][7:0]);
      chk("R10 oe during read", oev, 1);
    end
    chk("R10 oe idle after read", bus_ad_oe, 0);
    chk("R10 one read strobe per read", re_cnt - base_re, 6);

    // R6 exact write timing
    bus_addr = 8'h20; bus_ad_in = 8'h44; bus_cs_n = 1'b0; step();
    bus_wr_n = 1'b0; step();
    bus_wr_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6 no strobe after two edges", reg_we, 0);
    @(negedge clk);
    chk("R6 strobe at third edge", reg_we, 1);
    @(negedge clk);
    chk("R6 strobe lasts one cycle", reg_we, 0);
    bus_cs_n = 1'b1; step();
    chk("R6 timed write data", mem[8'h20], 8'h44);

    // R6 chip select high: no write
    base_we = we_cnt;
    bus_addr = 8'h21; bus_ad_in = 8'h12; step();
    bus_wr_n = 1'b0; step(); bus_wr_n = 1'b1; step();
    chk("R6 no write with cs high", we_cnt, base_we);

    // R2 direction/data-strobe activity ignored
    bus_cs_n = 1'b0; bus_rw = 1'b0; step();
    bus_ds_n = 1'b0; step(); bus_ds_n = 1'b1; step();
    bus_cs_n = 1'b1; bus_rw = 1'b1; step();
    chk("R2 ds strobe ignored", we_cnt, base_we);

    // ---------- strobe-and-direction, direct ----------
    do_reset(1'b0, 1'b1);
    chk("R1 oe after reset high ale", bus_ad_oe, 0);
    wr_strb(8'h10, 8'hC3);
    chk("R3 write address", last_wa, 8'h10);
    chk("R3 write data", last_wd, 8'hC3);
    base_re = re_cnt;
    rd_strb(8'h10, rdv, oev);
    chk("R3 read data", rdv, 8'hC3);
    chk("R10 oe during strobe read", oev, 1);
    chk("R10 read strobe count", re_cnt - base_re, 1);
    base_we = we_cnt;
    bus_addr = 8'h11; bus_ad_in = 8'h5F; bus_cs_n = 1'b0; step();
    bus_wr_n = 1'b0; step(); bus_wr_n = 1'b1; step();
    chk("R3 wr_n ignored", we_cnt, base_we);
    bus_rd_n = 1'b0; step(); step();
    chk("R3 rd_n gives no oe", bus_ad_oe, 0);
    bus_rd_n = 1'b1; bus_cs_n = 1'b1; step();

    // ---------- multiplexed ----------
    do_reset(1'b0, 1'b0);
    bus_addr = 8'h99;
    latch_addr(8'h22);
    wr_sep(8'h99, 8'h77);
    chk("R5 latched address used", last_wa, 8'h22);
    chk("R5 data phase", last_wd, 8'h77);
    latch_addr(8'h22);
    rd_sep(8'h99, rdv, oev);
    chk("R5 multiplexed read", rdv, 8'h77);
    bus_ale = 1'b1; step(); step();
    base_we = we_cnt;
    wr_sep(8'h33, 8'h11);
    chk("R4 still multiplexed with ale high", we_cnt, base_we + 1);
    chk("R4 address kept from latch", last_wa, 8'h22);
    do_reset(1'b0, 1'b1);
    base_we = we_cnt;
    wr_sep(8'h33, 8'h11);
    chk("R4 reset restores level style", we_cnt, base_we);

    // ---------- indirect ----------
    do_reset(1'b1, 1'b0);
    base_we = we_cnt; base_re = re_cnt;
    wr_sep(8'hFE, 8'h40);
    chk("R8 pointer write no strobe", we_cnt, base_we);
    rd_sep(8'hFE, rdv, oev);
    chk("R8 pointer read", rdv, 8'h40);
    chk("R8 pointer read no strobe", re_cnt, base_re);
    wr_sep(8'hFF, 8'h5A);
    chk("R9 window write address", last_wa, 8'h40);
    chk("R9 window write data", last_wd, 8'h5A);
    rd_sep(8'hFF, rdv, oev);
    chk("R9 window read", rdv, 8'h5A);
    chk("R9 window read strobe", re_cnt, base_re + 1);
    rd_sep(8'h01, rdv, oev);
    chk("R8 upper bits ignored", rdv, 8'h5A);
    wr_sep(8'h02, 8'h03);
    rd_sep(8'h01, rdv, oev);
    chk("R8 pointer via bit0 only", rdv, 8'hA5);

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule